// File: doc/BRIEF.md
# Asynchronous Byte SRAM Cycle Sequencer

This block runs read and write cycles on an external asynchronous static RAM of 8192 bytes. It drives active-low chip-enable, output-enable and write-enable strobes, a 13-bit address and an 8-bit data bus. The data bus is split into an output value, an output enable and an input value, and the pad ring joins them into one tri-state bus. On the system side a single request channel carries the direction, the address and the write byte. A response strobe returns the read byte, or an error flag when a write was refused.

Every cycle passes through the same sequence. First the address settles with all strobes inactive. Then the strobes are active for a parameterised number of clocks. One hold clock follows. A recovery gap with all strobes high comes after it, before the next request can be taken. Reads keep write-enable high throughout. Writes keep output-enable high throughout. In a write the controller drives the bus only while write-enable is low, and it lets go of the bus one clock before write-enable rises.

A power-fail input refuses writes. A write whose setup clock sees power-fail high is answered with the error flag, and the RAM sees no strobe. A write whose strobes have already started always runs to completion. Reads are unaffected. The request channel uses valid/ready: the requester holds `req_valid` and the request fields stable until a clock edge where `req_ready` is also high. `req_ready` stays low from that edge until the recovery gap has ended. The response channel cannot be held off. `rsp_valid` is a one-clock pulse that the requester must take when it appears.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and after reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. The direction (`req_write`=1 for a write), the address and the write byte are captured at that edge, and `req_ready` is 0 in the clock that follows.
- R3: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for ACC_CYC+1 clocks. `rsp_valid` is 1 for one clock, during the (ACC_CYC+2)-th clock after the accepting edge, with `rsp_err`=0 and `rsp_rdata` equal to the byte stored at the address.
- R4: A write holds `mem_ce_n` and `mem_we_n` low for WP_CYC+1 clocks. `mem_dq_oe` is 1 for the first WP_CYC of those clocks and 0 in the last one. `rsp_valid` is 1 for one clock, during the (WP_CYC+2)-th clock after the accepting edge.
- R5: `mem_oe_n` is never low while `mem_we_n` is low, and `mem_dq_oe` is never 1 while `mem_we_n` is high.
- R6: `mem_addr` does not change while `mem_ce_n` is low.
- R7: After the strobes rise, all strobes stay high for at least REC_CYC clocks. `req_ready` returns to 1 in the (REC_CYC+1)-th clock after the response clock.
- R8: A write with `pwr_fail`=1 in the clock after acceptance never lowers `mem_ce_n` or `mem_we_n`. It is answered with `rsp_valid`=1 and `rsp_err`=1 in the second clock after acceptance, `req_ready` returns one clock later, and the stored byte is left unchanged.
- R9: If `pwr_fail` rises after the write strobes have started, the write completes with its full pulse, `rsp_err`=0, and the new byte is stored.
- R10: A read issued while `pwr_fail`=1 runs normally, with `rsp_err`=0 and correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Write refused because of power-fail |
| rsp_rdata | output | 8 | Byte read |
| pwr_fail | input | 1 | Supply-low indication, synchronous to clk |
| mem_addr | output | 13 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_oe | output | 1 | Enables the data-out drivers |
| mem_dq_in | input | 8 | Data from the RAM |

## Verification
Take the accepting edge as edge 0 and count clocks from there. The response is due in clock ACC_CYC+2 for a read, in clock WP_CYC+2 for a write, and in clock 2 for a refused write. `req_ready` comes back REC_CYC+1 clocks after a normal response and 1 clock after an error response. The bench counts falling edges from the accepting edge and compares the count at the first `rsp_valid` with the number computed for that request type. On every falling edge, a strobe monitor measures the write-pulse and bus-drive lengths, the strobe overlap, the address hold and the gap between cycles. A behavioural RAM applies each write when write-enable rises, and read data is compared against a scoreboard of the accepted writes.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_ACTIVE  = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RECOVER = 3'd4
  } seq_state_t;
endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int ACC_CYC = 3,
  parameter int WP_CYC  = 2,
  parameter int REC_CYC = 2,
  parameter int CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             pwr_fail,
  input  logic             tmr_zero,
  output logic             req_ready,
  output logic             accept,
  output seq_state_t       st_q,
  output seq_state_t       st_d,
  output logic             wr_q,
  output logic             err_q,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);
  localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

  logic abort;

  assign req_ready = (st_q == ST_IDLE) && !err_q;
  assign accept    = req_valid && req_ready;
  assign abort     = (st_q == ST_SETUP) && wr_q && pwr_fail;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE:    if (accept) st_d = ST_SETUP;
      ST_SETUP: begin
        if (abort) st_d = ST_IDLE;
        else begin
          st_d     = ST_ACTIVE;
          tmr_load = 1'b1;
          tmr_val  = wr_q ? WP_LD : ACC_LD;
        end
      end
      ST_ACTIVE:  if (tmr_zero) st_d = ST_HOLD;
      ST_HOLD: begin
        st_d     = ST_RECOVER;
        tmr_load = 1'b1;
        tmr_val  = REC_LD;
      end
      ST_RECOVER: if (tmr_zero) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      wr_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= abort;
      if (accept) wr_q <= req_write;
    end
  end

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(st_q) == ST_SETUP) && $past(pwr_fail));

  // R2
  taken_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  seq_state_t        st_q,
  input  seq_state_t        st_d,
  input  logic              wr_q,
  input  logic              tmr_zero,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rdata
);
  logic on_d;
  logic rd_capture;

  assign on_d       = (st_d == ST_ACTIVE) || (st_d == ST_HOLD);
  assign rd_capture = (st_q == ST_ACTIVE) && tmr_zero && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_ce_n  <= !on_d;
      mem_oe_n  <= !(on_d && !wr_q);
      mem_we_n  <= !(on_d && wr_q);
      mem_dq_oe <= (st_d == ST_ACTIVE) && wr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (rd_capture) rdata <= mem_dq_in;
  end

  // R5
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R5
  dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R4
  release_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> !mem_we_n);
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 3,
  parameter int WP_CYC  = 2,
  parameter int REC_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              pwr_fail,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int MAX_AW = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
  localparam int MAX_C  = (MAX_AW > REC_CYC) ? MAX_AW : REC_CYC;
  localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  seq_state_t       st_q, st_d;
  logic             accept, wr_q, err_q, tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  sram_seq_fsm #(
    .ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .CNT_W(CNT_W)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .pwr_fail(pwr_fail), .tmr_zero(tmr_zero), .req_ready(req_ready),
    .accept(accept), .st_q(st_q), .st_d(st_d), .wr_q(wr_q), .err_q(err_q),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sram_seq_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .zero(tmr_zero)
  );

  sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .st_q(st_q), .st_d(st_d), .wr_q(wr_q),
    .tmr_zero(tmr_zero), .mem_dq_in(mem_dq_in), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .rdata(rsp_rdata)
  );

  assign rsp_valid = (st_q == ST_HOLD) || err_q;
  assign rsp_err   = err_q;

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  recover_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |=> mem_ce_n && mem_we_n && mem_oe_n);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> mem_ce_n && mem_we_n && !mem_dq_oe);

  // R3
  done_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> !mem_ce_n);
endmodule

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_seq_ctrl_tb_top;
  localparam int ACC = 3;
  localparam int WP  = 2;
  localparam int REC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, pwr_fail = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_out;
  logic [7:0]  mem_dq_in = '0;
  logic [12:0] mem_addr;

  int total = 0;
  int bad = 0;

  sram_seq_ctrl #(.ACC_CYC(ACC), .WP_CYC(WP), .REC_CYC(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .pwr_fail(pwr_fail), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  function automatic int exp_lat(input bit wr, input bit abort);
    if (abort) return 2;
    return wr ? WP + 2 : ACC + 2;
  endfunction

  // behavioural RAM and strobe monitor
  logic [7:0] ram_m [int];
  logic [7:0] exp_m [int];
  int we_lo = 0, dq_cnt = 0, gap = 0, we_falls = 0;
  bit prev_we_n = 1'b1, prev_ce_n = 1'b1, wpend = 1'b0, seen_ce = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wbuf = '0;

  function automatic logic [7:0] ram_rd(input logic [12:0] a);
    return ram_m.exists(int'(a)) ? ram_m[int'(a)] : dflt(a);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n) begin
        if (prev_we_n) begin we_falls++; wr_addr = mem_addr; end
        we_lo++;
        if (mem_dq_oe) begin dq_cnt++; wbuf = mem_dq_out; wpend = 1'b1; end
        if (!mem_oe_n) chk(1'b0, "R5 oe low in write", 0, 1);
        if (mem_addr != wr_addr) chk(1'b0, "R6 addr moved", int'(mem_addr), int'(wr_addr));
      end else if (!prev_we_n) begin
        chk(we_lo == WP + 1, "R4 we pulse", we_lo, WP + 1);
        chk(dq_cnt == WP, "R4 drive length", dq_cnt, WP);
        if (wpend) ram_m[int'(wr_addr)] = wbuf;
        wpend = 1'b0; we_lo = 0; dq_cnt = 0;
      end
      if (mem_dq_oe && mem_we_n) chk(1'b0, "R5 drive with we high", 1, 0);
      if (mem_ce_n) gap++;
      else if (prev_ce_n) begin
        if (seen_ce) chk(gap >= REC + 1, "R7 gap", gap, REC + 1);
        gap = 0; seen_ce = 1'b1;
      end
      prev_we_n = mem_we_n;
      prev_ce_n = mem_ce_n;
      mem_dq_in <= (!mem_ce_n && !mem_oe_n) ? ram_rd(mem_addr) : 8'h00;
    end
  end

  task automatic do_req(input bit wr, input logic [12:0] a, input logic [7:0] d,
                        input int pf_at);
    int lat, n, wf0;
    bit abort;
    logic [7:0] ev;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    n = 0;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
    wf0 = we_falls;
    abort = wr && (pwr_fail || pf_at == 1);
    ev = exp_m.exists(int'(a)) ? exp_m[int'(a)] : dflt(a);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        chk(!req_ready, "R2 busy after accept", req_ready, 0);
        req_valid = 1'b0;
      end
      if (lat == pf_at) pwr_fail = 1'b1;
    end while (!rsp_valid && lat < 40);
    chk(lat == exp_lat(wr, abort), wr ? (abort ? "R8 latency" : "R4 latency") : "R3 latency",
        lat, exp_lat(wr, abort));
    chk(rsp_err == abort, wr ? (abort ? "R8 err" : "R9 err") : "R10 err", rsp_err, abort);
    if (!wr) chk(rsp_rdata == ev, "R3 rdata", rsp_rdata, ev);
    if (wr && !abort) exp_m[int'(a)] = d;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ready && n < 40);
    chk(n == (abort ? 1 : REC + 1), "R7 ready return", n, abort ? 1 : REC + 1);
    if (wr) chk(we_falls == wf0 + (abort ? 0 : 1), abort ? "R8 no strobe" : "R9 one pulse",
                we_falls - wf0, abort ? 0 : 1);
  endtask

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
        "R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
        "R1 strobes after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 5'b11100);

    // directed
    do_req(1'b0, 13'h0123, 8'h00, 0);          // R3 unwritten byte
    do_req(1'b1, 13'h0000, 8'h5A, 0);          // R4 lowest address
    do_req(1'b1, 13'h1FFF, 8'hC3, 0);          // R4 highest address
    do_req(1'b0, 13'h0000, 8'h00, 0);          // R3
    do_req(1'b0, 13'h1FFF, 8'h00, 0);          // R3
    pwr_fail = 1'b1;
    do_req(1'b1, 13'h0000, 8'hEE, 0);          // R8 refused before request
    do_req(1'b0, 13'h0000, 8'h00, 0);          // R10 read under power-fail
    pwr_fail = 1'b0;
    do_req(1'b1, 13'h1FFF, 8'h11, 1);          // R8 raised during setup
    pwr_fail = 1'b0;
    do_req(1'b0, 13'h1FFF, 8'h00, 0);          // R8 byte unchanged
    do_req(1'b1, 13'h0AAA, 8'h77, 2);          // R9 raised in first strobe clock
    pwr_fail = 1'b0;
    do_req(1'b1, 13'h0555, 8'h99, WP + 1);     // R9 raised in last drive clock
    pwr_fail = 1'b0;
    do_req(1'b0, 13'h0AAA, 8'h00, 0);          // R9 byte stored
    do_req(1'b0, 13'h0555, 8'h00, 0);          // R9

    // random
    for (int i = 0; i < 150; i++) begin
      logic [12:0] a;
      bit wr;
      int pf;
      a  = 13'($urandom) & 13'h1C07;
      wr = ($urandom % 2) == 1;
      pf = 0;
      pwr_fail = ($urandom % 10) == 0;
      if (!pwr_fail && ($urandom % 8) == 0) pf = 1 + ($urandom % 3);
      do_req(wr, a, 8'($urandom), pf);
      pwr_fail = 1'b0;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule